// File: doc/BRIEF.md
# Rename-Stage Move Elimination Classifier

This block sits in the rename stage of an out-of-order core and decides, for each register move presented in a rename group, whether that move can be retired at allocation by sharing a physical register. It can also send the move down the normal path as a single-cycle ALU uop. An eliminated move costs no execution port and no scheduler entry, and it adds zero latency. The destination's rename-table entry is pointed at the physical register that already backs the source.

Each lane carries several fields:

- a move class: plain copy, zero-extend or sign-extend;
- source and destination architectural register numbers and operand sizes;
- flags that mark a high-byte alias on either side;
- the source register's high-byte dirty flag;
- the source's current physical register.

The block checks the move's shape against the elimination rules. It then hands out the cycle's limited elimination slots to eligible lanes in lane order. One cycle later it reports, for each lane, the path taken, any high-byte merge request, and the rename-table write.

Reference counting of shared physical registers is not part of this block. The caller supplies the number of elimination slots free in each cycle.

Top module: `mvelim_top`

## Requirements
- R1: While reset is asserted, and until the first valid move is registered, every lane shows out_valid 0, out_path 3 (none), out_map_we 0 and out_merge_req 0.
- R2: A valid zero-extend (op 1) is eliminated (out_path 0) one cycle after it is presented when all of the following hold: the source is an 8-bit (size code 0) low byte; the destination is 32-bit (size 2) or 64-bit (size 3) and not a high byte; the registers differ; and a slot is free. In that case out_map_we is 1, out_map_arch is the destination register and out_map_preg is the source physical register.
- R3: A plain copy (op 0) between distinct registers is eliminated only when both sizes are equal and are 32 or 64 bits. A plain copy with unequal sizes takes out_path 1 (ALU, refused by rule).
- R4: A move whose source and destination register numbers are equal is never eliminated, whatever its class or sizes, and takes out_path 1.
- R5: A zero-extend from a 16-bit source (size 1) is refused and takes out_path 1.
- R6: A move whose source is a high-byte alias, or whose destination is a high-byte alias, is refused and takes out_path 1.
- R7: A sign-extend (op 2) is never eliminated and takes out_path 1.
- R8: A move with an 8-bit or 16-bit destination is refused and takes out_path 1.
- R9: out_merge_req is 1 exactly when the lane is eliminated and its source dirty flag was set. A refused lane, or a lane that ran out of slots, never requests a merge.
- R10: Eligible lanes take elimination slots from lane 0 upward, at most in_slots of them per cycle. Ineligible lanes consume no slot. An eligible lane left without a slot takes out_path 2 (ALU, no slot) with out_map_we 0.
- R11: A lane with in_valid 0 gives out_valid 0, out_path 3 and out_map_we 0 one cycle later, and it does not disturb the other lanes of the same group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | NLANES | Lane holds a move this cycle |
| in_op | input | NLANES x 2 | Move class: 0 copy, 1 zero-extend, 2 sign-extend, 3 refused |
| in_src_arch | input | NLANES x AW | Source architectural register number |
| in_dst_arch | input | NLANES x AW | Destination architectural register number |
| in_src_size | input | NLANES x 2 | Source size: 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| in_dst_size | input | NLANES x 2 | Destination size, same coding |
| in_src_hi | input | NLANES | Source is a high-byte alias |
| in_dst_hi | input | NLANES | Destination is a high-byte alias |
| in_src_dirty | input | NLANES | Source register's high byte is held apart (dirty) |
| in_src_preg | input | NLANES x PW | Physical register currently backing the source |
| in_slots | input | CW | Elimination slots available this cycle |
| out_valid | output | NLANES | Registered lane valid |
| out_path | output | NLANES x 2 | 0 eliminated, 1 ALU by rule, 2 ALU for lack of slot, 3 none |
| out_merge_req | output | NLANES | High-byte merge uop needed before the mapping is shared |
| out_map_we | output | NLANES | Write the rename table for this lane |
| out_map_arch | output | NLANES x AW | Rename-table entry to write |
| out_map_preg | output | NLANES x PW | Physical register to store in that entry |

## Verification
The bench builds the block with three lanes, sixteen architectural registers and sixty-four physical registers. With three lanes, slot counts from zero to three produce full starvation, partial grants and surplus slots. They also make it possible to put an ineligible lane ahead of eligible ones, which shows whether refused moves wrongly consume a slot. The mid-group idle lane and dirty-source moves on every path are driven in the same groups, so merge and map-write gating are seen against their neighbours.

// File: rtl/mvelim_pkg.sv
package mvelim_pkg;

  typedef enum logic [1:0] {
    OP_MOV  = 2'd0,
    OP_ZEXT = 2'd1,
    OP_SEXT = 2'd2,
    OP_RSVD = 2'd3
  } mv_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2,
    SZ_Q = 2'd3
  } mv_size_e;

  typedef enum logic [1:0] {
    PATH_ELIM      = 2'd0,
    PATH_ALU_RULE  = 2'd1,
    PATH_ALU_NORES = 2'd2,
    PATH_NONE      = 2'd3
  } mv_path_e;

endpackage

// File: rtl/mvelim_rules.sv
module mvelim_rules
  import mvelim_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          valid,
  input  logic [1:0]    op,
  input  logic [AW-1:0] src_arch,
  input  logic [AW-1:0] dst_arch,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  input  logic          src_hi,
  input  logic          dst_hi,
  output logic          eligible
);

  logic shape_ok;
  logic wide_dst;
  logic distinct;

  // Shape check per move class; sign-extend and reserved never qualify.
  always_comb begin
    case (op)
      OP_MOV:  shape_ok = (src_size == dst_size) && !src_hi;
      OP_ZEXT: shape_ok = (src_size == SZ_B) && !src_hi;
      default: shape_ok = 1'b0;
    endcase
  end

  // Narrow destinations keep upper bits live, so they cannot share a mapping.
  assign wide_dst = ((dst_size == SZ_D) || (dst_size == SZ_Q)) && !dst_hi;
  assign distinct = (src_arch != dst_arch);
  assign eligible = valid && shape_ok && wide_dst && distinct;

endmodule

// File: rtl/mvelim_slot_alloc.sv
module mvelim_slot_alloc #(
  parameter int unsigned NLANES = 2,
  parameter int unsigned CW     = 2
) (
  input  logic [NLANES-1:0] elig,
  input  logic [CW-1:0]     slots,
  output logic [NLANES-1:0] grant
);

  logic [CW-1:0] used;

  // Walk lanes in program order; each eligible lane takes the next free slot.
  always_comb begin
    used  = '0;
    grant = '0;
    for (int i = 0; i < NLANES; i++) begin
      if (elig[i] && (used < slots)) begin
        grant[i] = 1'b1;
        used     = used + CW'(1);
      end
    end
  end

endmodule

// File: rtl/mvelim_top.sv
module mvelim_top
  import mvelim_pkg::*;
#(
  parameter int unsigned NLANES = 2,
  parameter int unsigned AREGS  = 16,
  parameter int unsigned PREGS  = 128,
  localparam int unsigned AW    = $clog2(AREGS),
  localparam int unsigned PW    = $clog2(PREGS),
  localparam int unsigned CW    = $clog2(NLANES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NLANES-1:0]             in_valid,
  input  logic [NLANES-1:0][1:0]        in_op,
  input  logic [NLANES-1:0][AW-1:0]     in_src_arch,
  input  logic [NLANES-1:0][AW-1:0]     in_dst_arch,
  input  logic [NLANES-1:0][1:0]        in_src_size,
  input  logic [NLANES-1:0][1:0]        in_dst_size,
  input  logic [NLANES-1:0]             in_src_hi,
  input  logic [NLANES-1:0]             in_dst_hi,
  input  logic [NLANES-1:0]             in_src_dirty,
  input  logic [NLANES-1:0][PW-1:0]     in_src_preg,
  input  logic [CW-1:0]                 in_slots,
  output logic [NLANES-1:0]             out_valid,
  output logic [NLANES-1:0][1:0]        out_path,
  output logic [NLANES-1:0]             out_merge_req,
  output logic [NLANES-1:0]             out_map_we,
  output logic [NLANES-1:0][AW-1:0]     out_map_arch,
  output logic [NLANES-1:0][PW-1:0]     out_map_preg
);

  logic [NLANES-1:0]         elig;
  logic [NLANES-1:0]         grant;
  logic [NLANES-1:0][1:0]    d_path;
  logic [NLANES-1:0]         d_merge;
  logic [NLANES-1:0]         d_we;

  logic [NLANES-1:0]         q_valid;
  logic [NLANES-1:0][1:0]    q_path;
  logic [NLANES-1:0]         q_merge;
  logic [NLANES-1:0]         q_we;
  logic [NLANES-1:0][AW-1:0] q_arch;
  logic [NLANES-1:0][PW-1:0] q_preg;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    mvelim_rules #(.AW(AW)) u_rules (
      .valid    (in_valid[g]),
      .op       (in_op[g]),
      .src_arch (in_src_arch[g]),
      .dst_arch (in_dst_arch[g]),
      .src_size (in_src_size[g]),
      .dst_size (in_dst_size[g]),
      .src_hi   (in_src_hi[g]),
      .dst_hi   (in_dst_hi[g]),
      .eligible (elig[g])
    );
  end

  mvelim_slot_alloc #(.NLANES(NLANES), .CW(CW)) u_alloc (
    .elig  (elig),
    .slots (in_slots),
    .grant (grant)
  );

  // Next-state: path code, merge request and map write per lane.
  always_comb begin
    for (int i = 0; i < NLANES; i++) begin
      if (!in_valid[i])      d_path[i] = PATH_NONE;
      else if (!elig[i])     d_path[i] = PATH_ALU_RULE;
      else if (grant[i])     d_path[i] = PATH_ELIM;
      else                   d_path[i] = PATH_ALU_NORES;
      d_we[i]    = grant[i];
      d_merge[i] = grant[i] & in_src_dirty[i];
    end
  end

  // Control registers: reset to idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= '0;
      q_path  <= {NLANES{2'(PATH_NONE)}};
      q_merge <= '0;
      q_we    <= '0;
    end else begin
      q_valid <= in_valid;
      q_path  <= d_path;
      q_merge <= d_merge;
      q_we    <= d_we;
    end
  end

  // Mapping datapath: no reset, loaded only for valid lanes.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NLANES; i++) begin
      if (in_valid[i]) begin
        q_arch[i] <= in_dst_arch[i];
        q_preg[i] <= in_src_preg[i];
      end
    end
  end

  assign out_valid     = q_valid;
  assign out_path      = q_path;
  assign out_merge_req = q_merge;
  assign out_map_we    = q_we;
  assign out_map_arch  = q_arch;
  assign out_map_preg  = q_preg;

  for (genvar a = 0; a < NLANES; a++) begin : g_chk
    // R2: a loaded lane carries the source physical register forward.
    p_preg_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[a] |=> (out_map_preg[a] == $past(in_src_preg[a])));
    // R4: same-register moves never take the eliminated path.
    p_same_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[a] && (in_src_arch[a] == in_dst_arch[a])) |=> (out_path[a] != PATH_ELIM));
    // R7: sign-extends always go to the ALU by rule.
    p_sext_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[a] && (in_op[a] == OP_SEXT)) |=> (out_path[a] == PATH_ALU_RULE));
    // R9: a merge request implies elimination of a dirty source.
    p_merge_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_merge_req[a] |-> ((out_path[a] == PATH_ELIM) && $past(in_src_dirty[a])));
    // R11: idle lanes show no path and write no mapping.
    p_idle_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[a] |-> ((out_path[a] == PATH_NONE) && !out_map_we[a]));
  end

  // R10: never more eliminations than slots offered.
  p_slot_budget_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_map_we) <= int'($past(in_slots))));

endmodule

// File: tb/mvelim_top_tb_top.sv
module mvelim_top_tb_top;
  import mvelim_pkg::*;

  localparam int NL = 3;
  localparam int AR = 16;
  localparam int PR = 64;
  localparam int AW = 4;
  localparam int PW = 6;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [NL-1:0]         in_valid;
  logic [NL-1:0][1:0]    in_op;
  logic [NL-1:0][AW-1:0] in_src_arch, in_dst_arch;
  logic [NL-1:0][1:0]    in_src_size, in_dst_size;
  logic [NL-1:0]         in_src_hi, in_dst_hi, in_src_dirty;
  logic [NL-1:0][PW-1:0] in_src_preg;
  logic [CW-1:0]         in_slots;
  logic [NL-1:0]         out_valid, out_merge_req, out_map_we;
  logic [NL-1:0][1:0]    out_path;
  logic [NL-1:0][AW-1:0] out_map_arch;
  logic [NL-1:0][PW-1:0] out_map_preg;

  mvelim_top #(.NLANES(NL), .AREGS(AR), .PREGS(PR)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src_arch(in_src_arch), .in_dst_arch(in_dst_arch),
    .in_src_size(in_src_size), .in_dst_size(in_dst_size),
    .in_src_hi(in_src_hi), .in_dst_hi(in_dst_hi), .in_src_dirty(in_src_dirty),
    .in_src_preg(in_src_preg), .in_slots(in_slots),
    .out_valid(out_valid), .out_path(out_path), .out_merge_req(out_merge_req),
    .out_map_we(out_map_we), .out_map_arch(out_map_arch), .out_map_preg(out_map_preg)
  );

  typedef struct {
    string                 tag;
    logic [NL-1:0][1:0]    path;
    logic [NL-1:0]         merge;
    logic [NL-1:0][AW-1:0] arch;
    logic [NL-1:0][PW-1:0] preg;
  } exp_t;

  exp_t q[$];
  exp_t st_exp;
  int   nchk = 0;
  int   nerr = 0;
  bit   done = 1'b0;

  logic [NL-1:0]         s_valid, s_shi, s_dhi, s_dirty;
  logic [NL-1:0][1:0]    s_op, s_ssz, s_dsz;
  logic [NL-1:0][AW-1:0] s_src, s_dst;
  logic [NL-1:0][PW-1:0] s_preg;

  task automatic clear_stage();
    s_valid = '0; s_shi = '0; s_dhi = '0; s_dirty = '0;
    s_op = '0; s_ssz = '0; s_dsz = '0; s_src = '0; s_dst = '0; s_preg = '0;
    for (int l = 0; l < NL; l++) begin
      st_exp.path[l]  = PATH_NONE;
      st_exp.merge[l] = 1'b0;
      st_exp.arch[l]  = '0;
      st_exp.preg[l]  = '0;
    end
  endtask

  task automatic set_lane(int l, logic [1:0] op, logic [AW-1:0] src, logic [AW-1:0] dst,
                          logic [1:0] ssz, logic [1:0] dsz, logic shi, logic dhi,
                          logic dirty, logic [PW-1:0] preg, logic [1:0] ep, logic em);
    s_valid[l] = 1'b1; s_op[l] = op; s_src[l] = src; s_dst[l] = dst;
    s_ssz[l] = ssz; s_dsz[l] = dsz; s_shi[l] = shi; s_dhi[l] = dhi;
    s_dirty[l] = dirty; s_preg[l] = preg;
    st_exp.path[l] = ep; st_exp.merge[l] = em;
    st_exp.arch[l] = dst; st_exp.preg[l] = preg;
  endtask

  // Driver: apply the staged group away from the edge and queue its expectation.
  task automatic fire(string tag, int slots);
    @(negedge clk);
    in_valid = s_valid; in_op = s_op; in_src_arch = s_src; in_dst_arch = s_dst;
    in_src_size = s_ssz; in_dst_size = s_dsz; in_src_hi = s_shi; in_dst_hi = s_dhi;
    in_src_dirty = s_dirty; in_src_preg = s_preg; in_slots = CW'(slots);
    st_exp.tag = tag;
    q.push_back(st_exp);
    clear_stage();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  // Monitor: results of the group driven before this edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin : mon
      exp_t e;
      e = q.pop_front();
      for (int l = 0; l < NL; l++) begin
        nchk++;
        if (out_valid[l] !== (e.path[l] != PATH_NONE) || out_path[l] !== e.path[l] ||
            out_merge_req[l] !== e.merge[l] || out_map_we[l] !== (e.path[l] == PATH_ELIM)) begin
          nerr++;
          $display("FAIL %s lane %0d: valid=%0b path=%0d merge=%0b we=%0b expected path=%0d merge=%0b",
                   e.tag, l, out_valid[l], out_path[l], out_merge_req[l], out_map_we[l],
                   e.path[l], e.merge[l]);
        end
        if (e.path[l] == PATH_ELIM) begin
          nchk++;
          if (out_map_arch[l] !== e.arch[l] || out_map_preg[l] !== e.preg[l]) begin
            nerr++;
            $display("FAIL %s lane %0d mapping: arch=%0d preg=%0d expected arch=%0d preg=%0d",
                     e.tag, l, out_map_arch[l], out_map_preg[l], e.arch[l], e.preg[l]);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    nerr++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    clear_stage();
    in_valid = '0; in_op = '0; in_src_arch = '0; in_dst_arch = '0;
    in_src_size = '0; in_dst_size = '0; in_src_hi = '0; in_dst_hi = '0;
    in_src_dirty = '0; in_src_preg = '0; in_slots = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      nchk++;
      if (out_valid[l] !== 1'b0 || out_path[l] !== 2'(PATH_NONE) ||
          out_map_we[l] !== 1'b0 || out_merge_req[l] !== 1'b0) begin
        nerr++;
        $display("FAIL R1 lane %0d: valid=%0b path=%0d we=%0b merge=%0b expected 0 3 0 0",
                 l, out_valid[l], out_path[l], out_map_we[l], out_merge_req[l]);
      end
    end
    rst_n = 1'b1;

    // R2: byte zero-extends into 32 and 64 bits, distinct registers
    set_lane(0, OP_ZEXT, 1, 2, SZ_B, SZ_D, 0, 0, 0, 5,  PATH_ELIM, 0);
    set_lane(1, OP_ZEXT, 3, 4, SZ_B, SZ_Q, 0, 0, 0, 41, PATH_ELIM, 0);
    fire("R2", 3);
    // R3: equal-size full-width copies, and a size mismatch
    set_lane(0, OP_MOV, 5, 6, SZ_Q, SZ_Q, 0, 0, 0, 17, PATH_ELIM, 0);
    set_lane(1, OP_MOV, 7, 8, SZ_D, SZ_D, 0, 0, 0, 63, PATH_ELIM, 0);
    set_lane(2, OP_MOV, 9, 10, SZ_D, SZ_Q, 0, 0, 0, 2, PATH_ALU_RULE, 0);
    fire("R3", 3);
    // R4: same-register copy and same-register byte zero-extend
    set_lane(0, OP_MOV,  7, 7, SZ_Q, SZ_Q, 0, 0, 0, 9,  PATH_ALU_RULE, 0);
    set_lane(1, OP_ZEXT, 3, 3, SZ_B, SZ_D, 0, 0, 0, 11, PATH_ALU_RULE, 0);
    set_lane(2, OP_MOV, 15, 15, SZ_D, SZ_D, 0, 0, 1, 12, PATH_ALU_RULE, 0);
    fire("R4", 3);
    // R5: zero-extends from 16-bit sources
    set_lane(0, OP_ZEXT, 1, 2, SZ_W, SZ_D, 0, 0, 0, 3, PATH_ALU_RULE, 0);
    set_lane(2, OP_ZEXT, 4, 5, SZ_W, SZ_Q, 0, 0, 0, 4, PATH_ALU_RULE, 0);
    fire("R5", 3);
    // R6: high-byte source and high-byte destination
    set_lane(0, OP_ZEXT, 1, 2, SZ_B, SZ_D, 1, 0, 0, 6, PATH_ALU_RULE, 0);
    set_lane(1, OP_MOV,  3, 4, SZ_B, SZ_B, 0, 1, 0, 7, PATH_ALU_RULE, 0);
    set_lane(2, OP_ZEXT, 6, 0, SZ_B, SZ_Q, 1, 0, 1, 8, PATH_ALU_RULE, 0);
    fire("R6", 3);
    // R7: sign-extends of every shape, plus reserved class
    set_lane(0, OP_SEXT, 1, 2, SZ_B, SZ_D, 0, 0, 0, 13, PATH_ALU_RULE, 0);
    set_lane(1, OP_SEXT, 3, 4, SZ_W, SZ_Q, 0, 0, 0, 14, PATH_ALU_RULE, 0);
    set_lane(2, OP_RSVD, 5, 6, SZ_Q, SZ_Q, 0, 0, 0, 15, PATH_ALU_RULE, 0);
    fire("R7", 3);
    // R8: narrow destinations
    set_lane(0, OP_MOV,  1, 2, SZ_W, SZ_W, 0, 0, 0, 20, PATH_ALU_RULE, 0);
    set_lane(1, OP_MOV,  3, 4, SZ_B, SZ_B, 0, 0, 0, 21, PATH_ALU_RULE, 0);
    set_lane(2, OP_ZEXT, 5, 6, SZ_B, SZ_W, 0, 0, 0, 22, PATH_ALU_RULE, 0);
    fire("R8", 3);
    // R9: dirty sources on eliminated and refused lanes
    set_lane(0, OP_ZEXT, 1, 2, SZ_B, SZ_D, 0, 0, 1, 30, PATH_ELIM, 1);
    set_lane(1, OP_ZEXT, 3, 4, SZ_W, SZ_D, 0, 0, 1, 31, PATH_ALU_RULE, 0);
    set_lane(2, OP_MOV,  5, 6, SZ_Q, SZ_Q, 0, 0, 1, 32, PATH_ELIM, 1);
    fire("R9", 3);
    // R10: one slot, three eligible lanes (dirty starved lane: no merge, R9)
    set_lane(0, OP_MOV,  1, 2, SZ_Q, SZ_Q, 0, 0, 0, 33, PATH_ELIM, 0);
    set_lane(1, OP_ZEXT, 3, 4, SZ_B, SZ_D, 0, 0, 1, 34, PATH_ALU_NORES, 0);
    set_lane(2, OP_MOV,  5, 6, SZ_D, SZ_D, 0, 0, 0, 35, PATH_ALU_NORES, 0);
    fire("R10 one slot", 1);
    // R10: ineligible lane first consumes no slot
    set_lane(0, OP_SEXT, 1, 2, SZ_B, SZ_D, 0, 0, 0, 36, PATH_ALU_RULE, 0);
    set_lane(1, OP_ZEXT, 3, 4, SZ_B, SZ_Q, 0, 0, 0, 37, PATH_ELIM, 0);
    set_lane(2, OP_MOV,  5, 6, SZ_Q, SZ_Q, 0, 0, 1, 38, PATH_ELIM, 1);
    fire("R10 skip ineligible", 2);
    // R10: no slots at all
    set_lane(0, OP_MOV,  8, 9, SZ_Q, SZ_Q, 0, 0, 1, 39, PATH_ALU_NORES, 0);
    set_lane(1, OP_ZEXT, 10, 11, SZ_B, SZ_D, 0, 0, 0, 40, PATH_ALU_NORES, 0);
    set_lane(2, OP_MOV,  12, 13, SZ_D, SZ_D, 0, 0, 0, 42, PATH_ALU_NORES, 0);
    fire("R10 zero slots", 0);
    // R11: idle middle lane, later lane still gets the second slot
    set_lane(0, OP_MOV,  2, 3, SZ_Q, SZ_Q, 0, 0, 0, 43, PATH_ELIM, 0);
    set_lane(2, OP_ZEXT, 4, 12, SZ_B, SZ_D, 0, 0, 0, 44, PATH_ELIM, 0);
    fire("R11 gap", 2);
    // R11: whole group idle
    fire("R11 idle", 3);
    // R2: highest register numbers and physical register index
    set_lane(1, OP_ZEXT, 14, 15, SZ_B, SZ_Q, 0, 0, 0, 63, PATH_ELIM, 0);
    fire("R2 edge", 1);
    fire("R11 tail", 0);

    repeat (3) @(posedge clk);
    #3;
    nchk++;
    if (q.size() != 0) begin
      nerr++;
      $display("FAIL R11 scoreboard: %0d items left, expected 0", q.size());
    end
    finish_run();
  end

endmodule